// File: doc/BRIEF.md
# Multiply-Step Unit with Condition Flags

The block multiplies two 32-bit unsigned numbers with a shift-and-add datapath that advances one multiply step per clock. Each step works on a partial-product register, a Y register and four condition flags: negative (N), zero (Z), overflow (V) and carry (C). The step halves the partial product and puts the true sign of the previous sum (N XOR V) in its top bit. It adds the multiplicand only when the old Y bit 0 is one. It moves the bit that dropped out of the partial product into the top of Y. It then rebuilds all four flags from that addition.

A small sequencer starts the operation. It loads Y with the multiplier, clears the partial product and the flags, then issues 32 gated steps and one last step whose addend is forced to zero. The steps treat the multiplicand as signed. For that reason the high word gets one unsigned fix-up in the last cycle: the multiplier is added to it when the multiplicand's bit 31 is set. The 64-bit product is then the partial product (high word) joined to Y (low word), and `done` pulses for one cycle.

Top module: `msu_top`

## Requirements
- R1: While reset is low and after it is released, before any start, `done` is 0 and `product` is 0.
- R2: For any operands, `product` equals the unsigned 64-bit product multiplicand × multiplier. Bits 63:32 hold the high word and bits 31:0 the low word.
- R3: `done` is high for exactly one cycle. It rises at the 33rd rising edge after the edge that accepts `start`.
- R4: A `start` seen while an operation is in progress is ignored. The running result is unchanged and no extra `done` follows.
- R5: Each step shifts the partial product right by one and places N XOR V of the flags before the step in bit 31.
- R6: The addend of a step is the multiplicand when the Y bit 0 before the step is 1, and zero otherwise.
- R7: Each step sets Y to {old partial-product bit 0, old Y bits 31:1}.
- R8: After each step Z is 1 exactly when the 32-bit sum is zero, and N equals bit 31 of the sum.
- R9: After each step C is 1 exactly when the unsigned sum is smaller than the shifted partial product (carry out of bit 31).
- R10: After each step V is 1 exactly when both addends share a sign bit and the sum's sign bit differs from it.
- R11: The 33rd step uses a zero addend, so it leaves C and V cleared. The high word gains the multiplier when multiplicand bit 31 is 1.
- R12: `product` holds its value after `done` until the next operation completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| multiplicand | input | 32 | Unsigned multiplicand, sampled with start |
| multiplier | input | 32 | Unsigned multiplier, sampled with start |
| product | output | 64 | Unsigned 64-bit result |
| done | output | 1 | One-cycle pulse when product is valid |

## Verification
The bench uses operands with bit 31 set on either side. A design that lost the unsigned fix-up or used a plain logical shift would then give high words that are wrong by exactly the multiplier. Operands of 0, 1 and all-ones test the Y gating and the extra zero-addend step. A missing final step shows up as a product off by a factor of two, and a gate read from the new Y shows up as a skewed product. A second start issued mid-run tests the busy guard: a design that restarted would return the wrong product or an extra done pulse. Timing each done against its start catches a step count that is off by one.

// File: rtl/msu_pkg.sv
package msu_pkg;
  localparam int MSU_W = 32;

  typedef logic [MSU_W-1:0] word_t;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  typedef struct packed {
    word_t  sum;
    flags_t fl;
  } add_res_t;

  // Halve the partial product, inserting the true sign of the last sum.
  function automatic word_t shift_in(input word_t pp, input flags_t fl);
    return {fl.n ^ fl.v, pp[MSU_W-1:1]};
  endfunction

  // Add two words and rebuild every flag from the result.
  function automatic add_res_t add_flags(input word_t a, input word_t b);
    add_res_t r;
    logic [MSU_W:0] wide;
    wide   = {1'b0, a} + {1'b0, b};
    r.sum  = wide[MSU_W-1:0];
    r.fl.n = wide[MSU_W-1];
    r.fl.z = (wide[MSU_W-1:0] == '0);
    r.fl.c = wide[MSU_W];
    r.fl.v = (a[MSU_W-1] == b[MSU_W-1]) && (wide[MSU_W-1] != a[MSU_W-1]);
    return r;
  endfunction
endpackage

// File: rtl/msu_step.sv
module msu_step
  import msu_pkg::*;
(
  input  word_t  pp,
  input  word_t  y,
  input  word_t  mcand,
  input  flags_t fl,
  input  logic   zero_add,
  output word_t  shifted,
  output word_t  addend,
  output word_t  pp_next,
  output word_t  y_next,
  output flags_t fl_next
);
  add_res_t res;

  always_comb begin
    shifted = shift_in(pp, fl);
    addend  = (y[0] && !zero_add) ? mcand : '0;
    res     = add_flags(shifted, addend);
    pp_next = res.sum;
    fl_next = res.fl;
    y_next  = {pp[0], y[MSU_W-1:1]};
  end
endmodule

// File: rtl/msu_seq.sv
module msu_seq #(
  parameter int STEPS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic busy,
  output logic last
);
  localparam int CW = $clog2(STEPS + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(STEPS);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign load = start && !busy_q;
  assign busy = busy_q;
  assign last = busy_q && (cnt_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (last) busy_q <= 1'b0;
      else      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/msu_top.sv
module msu_top
  import msu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [MSU_W-1:0]     multiplicand,
  input  logic [MSU_W-1:0]     multiplier,
  output logic [2*MSU_W-1:0]   product,
  output logic                 done
);
  logic   load, busy, last;
  word_t  pp_q, y_q, mcand_q, mplier_q;
  flags_t fl_q;
  word_t  shifted, addend, pp_next, y_next, hi_fixed;
  flags_t fl_next;
  logic [2*MSU_W-1:0] product_q;
  logic   done_q;

  msu_seq #(.STEPS(MSU_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .load(load), .busy(busy), .last(last)
  );

  msu_step u_step (
    .pp(pp_q), .y(y_q), .mcand(mcand_q), .fl(fl_q), .zero_add(last),
    .shifted(shifted), .addend(addend), .pp_next(pp_next),
    .y_next(y_next), .fl_next(fl_next)
  );

  // Steps treat the multiplicand as signed; restore the unsigned weight.
  assign hi_fixed = pp_next + (mcand_q[MSU_W-1] ? mplier_q : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pp_q      <= '0;
      y_q       <= '0;
      fl_q      <= '0;
      mcand_q   <= '0;
      mplier_q  <= '0;
      product_q <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= last;
      if (load) begin
        pp_q     <= '0;
        y_q      <= multiplier;
        fl_q     <= '0;
        mcand_q  <= multiplicand;
        mplier_q <= multiplier;
      end else if (busy) begin
        pp_q <= pp_next;
        y_q  <= y_next;
        fl_q <= fl_next;
        if (last) product_q <= {hi_fixed, y_next};
      end
    end
  end

  assign product = product_q;
  assign done    = done_q;
endmodule

// File: rtl/msu_checker.sv
module msu_checker
  import msu_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   busy,
  input logic   last,
  input logic   done,
  input word_t  pp_q,
  input word_t  y_q,
  input flags_t fl_q
);
  a_r5_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (last || !y_q[0]) |=> pp_q == {$past(fl_q.n ^ fl_q.v), $past(pp_q[MSU_W-1:1])});

  a_r7_y_update: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> y_q == {$past(pp_q[0]), $past(y_q[MSU_W-1:1])});

  a_r8_zero_neg: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (fl_q.z == (pp_q == '0)) && (fl_q.n == pp_q[MSU_W-1]));

  a_r9_carry: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last && y_q[0] |=>
      fl_q.c == (pp_q < {$past(fl_q.n ^ fl_q.v), $past(pp_q[MSU_W-1:1])}));

  a_r11_last_clean: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !fl_q.c && !fl_q.v);

  a_r3_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> done);

  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind msu_top msu_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .last(last), .done(done),
  .pp_q(pp_q), .y_q(y_q), .fl_q(fl_q)
);

// File: tb/msu_top_test.sv
module msu_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] multiplicand = '0;
  logic [31:0] multiplier = '0;
  logic [63:0] product;
  logic        done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct {
    logic [63:0] exp;
    int          issue;
  } item_t;
  item_t sb[$];

  msu_top uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .multiplicand(multiplicand), .multiplier(multiplier),
    .product(product), .done(done)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: issue one operation and queue its expected product.
  task automatic issue(input logic [31:0] a, input logic [31:0] b);
    item_t it;
    @(negedge clk);
    multiplicand = a;
    multiplier   = b;
    start        = 1'b1;
    it.exp       = {32'b0, a} * {32'b0, b};
    it.issue     = cyc;
    sb.push_back(it);
    @(negedge clk);
    start = 1'b0;
    repeat (36) @(negedge clk);
  endtask

  // Monitor: compare every done pulse against the scoreboard.
  logic [63:0] held;
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R4 unexpected done", {63'b0, done}, 64'b0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(product == it.exp, "R2 product", product, it.exp);
        check(cyc - it.issue == 34, "R3 latency", 64'(cyc - it.issue), 64'd34);
        held = product;
        @(negedge clk);
        check(!done, "R3 single-cycle done", {63'b0, done}, 64'b0);
        check(product == held, "R12 product held", product, held);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done in reset", {63'b0, done}, 64'b0);
    check(product == '0, "R1 product in reset", product, 64'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && product == '0, "R1 after reset", product, 64'b0);

    // Corner operands: R6 gating, R11 final step and fix-up
    issue(32'h0, 32'h0);
    issue(32'h1, 32'h1);
    issue(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    issue(32'h8000_0000, 32'h8000_0000);
    issue(32'hFFFF_FFFF, 32'h1);
    issue(32'h1, 32'hFFFF_FFFF);
    issue(32'h8000_0000, 32'h0000_0003);
    issue(32'h0000_0003, 32'h8000_0000);
    issue(32'h0, 32'hFFFF_FFFF);
    issue(32'h7FFF_FFFF, 32'h7FFF_FFFF);
    issue(32'hDEAD_BEEF, 32'hCAFE_F00D);

    // R4: second start mid-run must be ignored
    begin
      item_t it;
      @(negedge clk);
      multiplicand = 32'h1234_5678;
      multiplier   = 32'h9ABC_DEF0;
      start        = 1'b1;
      it.exp   = 64'h1234_5678 * 64'h9ABC_DEF0;
      it.issue = cyc;
      sb.push_back(it);
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      multiplicand = 32'h5;
      multiplier   = 32'h7;
      start        = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (70) @(negedge clk);
      check(sb.size() == 0, "R4 queue drained", 64'(sb.size()), 64'd0);
    end

    // R2/R5/R9/R10: random operands
    for (int i = 0; i < 24; i++) begin
      issue($urandom, $urandom);
    end

    repeat (5) @(negedge clk);
    check(sb.size() == 0, "R2 all results seen", 64'(sb.size()), 64'd0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule